// File: doc/BRIEF.md
# Memory Write Protection Unit

This unit sits beside the command decoder of a serial nonvolatile memory and decides whether a write may proceed. It holds the protection state (a two-bit block-protect level and a pin-enable bit), and it presents a status byte that also carries the busy flag and the write-enable latch. Both flags are supplied from outside the unit.

For every cycle the unit checks two kinds of request. An array write request carries a target address. A status-register write request carries a new status byte. The unit returns a combinational permit for each request. A permitted status write updates the protection state on the next clock edge. Array permits always use the protection state that was held before that edge.

Hardware locking needs two conditions together: the pin-enable bit is set and the external protect pin is low. While the lock holds, every status write is refused. As a result, the pin-enable bit cannot be cleared until the pin goes high again.

Top module: `wp_unit`

## Requirements
- R1: After reset, the block-protect level is 00 and the pin-enable bit is 0.
- R2: The status byte holds the busy input in bit 0, the write-enable latch input in bit 1, the block-protect level in bits 3:2 and the pin-enable bit in bit 7. Bits 6:4 always read 0.
- R3: `hw_lock_o` is 1 exactly when the pin-enable bit is 1 and `prot_pin_i` is low.
- R4: A status write is permitted exactly when it is requested, the write-enable latch is 1 and the hardware lock is off. On the next clock edge, bits 3:2 of `sr_wr_data_i` become the new level and bit 7 becomes the new pin-enable bit. Bits 6:4 and 1:0 of `sr_wr_data_i` have no effect.
- R5: A status write that is refused, or that is not requested, leaves the level and the pin-enable bit unchanged.
- R6: While the pin-enable bit is 1 and the pin is low, the pin-enable bit stays 1.
- R7: The protected address range depends on the level. Level 00 protects nothing. Level 01 protects the upper quarter, where the top two address bits are 11. Level 10 protects the upper half, where the top address bit is 1. Level 11 protects the whole array.
- R8: An array write is permitted exactly when it is requested, the write-enable latch is 1 and the address lies outside the protected range. The pin and the pin-enable bit have no effect on this decision.
- R9: When an array write and a status write arrive in the same cycle, the array permit is decided with the level held before that cycle's status write.
- R10: A permit output is 0 whenever its request is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prot_pin_i | input | 1 | External protect pin (low arms the hardware lock) |
| wel_i | input | 1 | Current write-enable latch state |
| busy_i | input | 1 | Programming-in-progress flag, shown in the status byte |
| arr_addr_i | input | ADDR_W | Target address of the array write |
| arr_wr_req_i | input | 1 | Array write request |
| sr_wr_req_i | input | 1 | Status-register write request |
| sr_wr_data_i | input | 8 | New status byte |
| arr_wr_ok_o | output | 1 | Array write permitted |
| sr_wr_ok_o | output | 1 | Status write permitted |
| hw_lock_o | output | 1 | Hardware lock active |
| status_o | output | 8 | Status byte |

## Verification
An array write and a status write can arrive in the same cycle. This is the overlap that matters, because the status write may move the block-protect level across the target address. The bench creates this overlap in two ways. A directed case raises the level from none to the whole array while it writes the top address. Random traffic also issues both requests together at a high rate. In each case the bench expects the array permit to follow the level held before the cycle, and it expects the new level to show in the status byte one cycle later.

// File: rtl/wp_pkg.sv
package wp_pkg;
    typedef enum logic [1:0] {
        LVL_NONE    = 2'b00,
        LVL_QUARTER = 2'b01,
        LVL_HALF    = 2'b10,
        LVL_ALL     = 2'b11
    } prot_lvl_t;

    typedef struct packed {
        prot_lvl_t lvl;
        logic      pin_en;
    } prot_regs_t;

    localparam int SR_W        = 8;
    localparam int SR_BUSY     = 0;
    localparam int SR_WEL      = 1;
    localparam int SR_LVL_LO   = 2;
    localparam int SR_PIN_EN   = 7;
endpackage

// File: rtl/wp_range_decode.sv
module wp_range_decode
    import wp_pkg::*;
(
    input  prot_lvl_t  lvl,
    input  logic [1:0] addr_top,
    output logic       hit
);
    always_comb begin
        unique case (lvl)
            LVL_NONE:    hit = 1'b0;
            LVL_QUARTER: hit = &addr_top;
            LVL_HALF:    hit = addr_top[1];
            default:     hit = 1'b1;
        endcase
    end
endmodule

// File: rtl/wp_gate.sv
module wp_gate (
    input  logic pin_high,
    input  logic pin_en,
    input  logic wel,
    input  logic range_hit,
    input  logic arr_req,
    input  logic sr_req,
    output logic lock,
    output logic arr_ok,
    output logic sr_ok
);
    always_comb begin
        lock   = pin_en & ~pin_high;
        arr_ok = arr_req & wel & ~range_hit;
        sr_ok  = sr_req & wel & ~lock;
    end
endmodule

// File: rtl/wp_unit.sv
module wp_unit
    import wp_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prot_pin_i,
    input  logic              wel_i,
    input  logic              busy_i,
    input  logic [ADDR_W-1:0] arr_addr_i,
    input  logic              arr_wr_req_i,
    input  logic              sr_wr_req_i,
    input  logic [SR_W-1:0]   sr_wr_data_i,
    output logic              arr_wr_ok_o,
    output logic              sr_wr_ok_o,
    output logic              hw_lock_o,
    output logic [SR_W-1:0]   status_o
);
    localparam int TOP_LSB = ADDR_W - 2;

    prot_regs_t regs_d, regs_q;
    logic       range_hit;
    logic       sr_ok;

    // Low address bits and read-only status fields do not take part in the decisions
    logic unused_inputs;
    assign unused_inputs = ^{arr_addr_i[TOP_LSB-1:0], sr_wr_data_i[6:4], sr_wr_data_i[1:0]};

    wp_range_decode u_range (
        .lvl      (regs_q.lvl),
        .addr_top (arr_addr_i[ADDR_W-1:TOP_LSB]),
        .hit      (range_hit)
    );

    wp_gate u_gate (
        .pin_high  (prot_pin_i),
        .pin_en    (regs_q.pin_en),
        .wel       (wel_i),
        .range_hit (range_hit),
        .arr_req   (arr_wr_req_i),
        .sr_req    (sr_wr_req_i),
        .lock      (hw_lock_o),
        .arr_ok    (arr_wr_ok_o),
        .sr_ok     (sr_ok)
    );

    assign sr_wr_ok_o = sr_ok;

    always_comb begin
        regs_d = regs_q;
        if (sr_ok) begin
            regs_d.lvl    = prot_lvl_t'(sr_wr_data_i[SR_LVL_LO +: 2]);
            regs_d.pin_en = sr_wr_data_i[SR_PIN_EN];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '{lvl: LVL_NONE, pin_en: 1'b0};
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        status_o                    = '0;
        status_o[SR_BUSY]           = busy_i;
        status_o[SR_WEL]            = wel_i;
        status_o[SR_LVL_LO +: 2]    = regs_q.lvl;
        status_o[SR_PIN_EN]         = regs_q.pin_en;
    end
endmodule

// File: rtl/wp_unit_chk.sv
module wp_unit_chk #(
    parameter int ADDR_W = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              prot_pin_i,
    input logic              wel_i,
    input logic [ADDR_W-1:0] arr_addr_i,
    input logic              arr_wr_req_i,
    input logic              sr_wr_req_i,
    input logic [7:0]        sr_wr_data_i,
    input logic              arr_wr_ok_o,
    input logic              sr_wr_ok_o,
    input logic              hw_lock_o,
    input logic [7:0]        status_o
);
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n) status_o[6:4] == 3'b000); // R2
    AST_LOCK_MATCH: assert property (@(posedge clk) disable iff (!rst_n) hw_lock_o == (status_o[7] && !prot_pin_i)); // R3
    AST_LOCK_REFUSE: assert property (@(posedge clk) disable iff (!rst_n) hw_lock_o |-> !sr_wr_ok_o); // R4
    AST_SR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        sr_wr_ok_o |=> (status_o[3:2] == $past(sr_wr_data_i[3:2])) && (status_o[7] == $past(sr_wr_data_i[7]))); // R4
    AST_SR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !sr_wr_ok_o |=> $stable(status_o[3:2]) && $stable(status_o[7])); // R5
    AST_PIN_EN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[7] && !prot_pin_i) |=> status_o[7]); // R6
    AST_ALL_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[3:2] == 2'b11) |-> !arr_wr_ok_o); // R7
    AST_NEED_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        !wel_i |-> (!arr_wr_ok_o && !sr_wr_ok_o)); // R8
    AST_NO_REQ_NO_OK: assert property (@(posedge clk) disable iff (!rst_n)
        (!arr_wr_req_i |-> !arr_wr_ok_o) and (!sr_wr_req_i |-> !sr_wr_ok_o)); // R10
    AST_TOP_BITS_DECIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_wr_req_i && wel_i && status_o[3:2] == 2'b10) |-> (arr_wr_ok_o == !arr_addr_i[ADDR_W-1])); // R7
endmodule

bind wp_unit wp_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .prot_pin_i   (prot_pin_i),
    .wel_i        (wel_i),
    .arr_addr_i   (arr_addr_i),
    .arr_wr_req_i (arr_wr_req_i),
    .sr_wr_req_i  (sr_wr_req_i),
    .sr_wr_data_i (sr_wr_data_i),
    .arr_wr_ok_o  (arr_wr_ok_o),
    .sr_wr_ok_o   (sr_wr_ok_o),
    .hw_lock_o    (hw_lock_o),
    .status_o     (status_o)
);

// File: tb/tb_wp_unit.sv
`timescale 1ns/1ps
module tb_wp_unit;
    localparam int AW = 15;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pin, wel, busy, areq, sreq;
    logic [AW-1:0] addr;
    logic [7:0]    sdata;
    logic          aok, sok, lock;
    logic [7:0]    status;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [1:0] m_lvl;
    logic       m_pen;

    always #5 clk = ~clk;

    wp_unit #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .prot_pin_i(pin), .wel_i(wel), .busy_i(busy),
        .arr_addr_i(addr), .arr_wr_req_i(areq), .sr_wr_req_i(sreq), .sr_wr_data_i(sdata),
        .arr_wr_ok_o(aok), .sr_wr_ok_o(sok), .hw_lock_o(lock), .status_o(status)
    );

    function automatic bit in_prot(logic [1:0] lvl, logic [AW-1:0] a);
        int unsigned ai = a;
        case (lvl)
            2'd0: return 1'b0;
            2'd1: return ai >= 3 * (1 << (AW - 2));
            2'd2: return ai >= (1 << (AW - 1));
            default: return 1'b1;
        endcase
    endfunction

    task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic step(string tag, logic p, logic w, logic b, logic [AW-1:0] a,
                        logic ar, logic sr, logic [7:0] d);
        logic e_lock, e_sok, e_aok;
        @(negedge clk);
        pin = p; wel = w; busy = b; addr = a; areq = ar; sreq = sr; sdata = d;
        #1;
        e_lock = m_pen & ~p;
        e_sok  = sr & w & ~e_lock;
        e_aok  = ar & w & ~in_prot(m_lvl, a);
        chk("R2", "status", status, {m_pen, 3'b000, m_lvl, w, b});
        chk("R3", "hw_lock", {7'd0, lock}, {7'd0, e_lock});
        chk({"R4/", tag}, "sr_ok", {7'd0, sok}, {7'd0, e_sok});
        chk({"R8/", tag}, "arr_ok", {7'd0, aok}, {7'd0, e_aok});
        if (e_sok) begin
            m_lvl = d[3:2];
            m_pen = d[7];
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        localparam logic [AW-1:0] TOP = '1;
        localparam logic [AW-1:0] Q3  = 3 << (AW - 2);
        localparam logic [AW-1:0] H   = 1 << (AW - 1);
        void'($urandom(32'd20240611));
        pin = 1; wel = 0; busy = 0; addr = '0; areq = 0; sreq = 0; sdata = '0;
        m_lvl = 2'b00; m_pen = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "reset status", status, 8'h00);
        @(negedge clk) rst_n = 1'b1;

        // R5: write without latch refused; R10 no request no permit
        step("R5", 0, 0, 1, TOP, 1, 1, 8'h8C);
        step("R10", 1, 1, 0, '0, 0, 0, 8'hFF);
        // R7 quarter boundary; R4 ignored bits 6:4 and 1:0
        step("R4", 1, 1, 0, '0, 0, 1, 8'h77);
        step("R7", 1, 1, 0, Q3 - 1, 1, 0, 8'h00);
        step("R7", 1, 1, 0, Q3, 1, 0, 8'h00);
        // R7 half boundary
        step("R4", 1, 1, 0, '0, 0, 1, 8'h08);
        step("R7", 1, 1, 0, H - 1, 1, 0, 8'h00);
        step("R7", 1, 1, 0, H, 1, 0, 8'h00);
        // R7 whole array, then none
        step("R4", 1, 1, 0, '0, 0, 1, 8'h0C);
        step("R7", 1, 1, 0, '0, 1, 0, 8'h00);
        step("R4", 1, 1, 0, '0, 0, 1, 8'h00);
        step("R7", 1, 1, 0, TOP, 1, 0, 8'h00);
        // R9: same-cycle raise to whole array while writing top
        step("R9", 1, 1, 0, TOP, 1, 1, 8'h0C);
        step("R9", 1, 1, 0, '0, 1, 0, 8'h00);
        // R6: arm pin enable, drop pin, try to clear
        step("R6", 1, 1, 0, '0, 0, 1, 8'h80);
        step("R6", 0, 1, 0, TOP, 1, 1, 8'h00);
        step("R6", 0, 1, 0, '0, 0, 1, 8'h0C);
        step("R6", 0, 1, 0, TOP, 1, 0, 8'h00);
        step("R6", 1, 1, 0, '0, 0, 1, 8'h00);
        step("R6", 0, 1, 0, '0, 0, 1, 8'h08);

        for (int i = 0; i < 3000; i++) begin
            logic [7:0] d = 8'($urandom);
            step("rnd", ($urandom % 3) != 0, ($urandom % 4) != 0, 1'($urandom),
                 AW'($urandom), ($urandom % 3) != 0, ($urandom % 3) == 0, d);
        end

        done = 1'b1;
        finish_run();
    end
endmodule